// File: doc/BRIEF.md
# Eight-Source Interrupt Request Controller

This block collects interrupt events for a small 8-bit processor core and turns them into a single vector request. It keeps one sticky flag bit and one enable bit for each of eight sources. Three sources belong to the core: an external pin with a selectable active edge, a change detector on the upper nibble of an input port, and a timer0 overflow pulse. Five sources are peripheral pulses: A/D done, timer2 match, serial port, capture/compare and timer1 overflow. These five also need a peripheral group enable.

A global enable gates the request to the CPU. When the CPU accepts the request, the global enable clears by itself. A return-from-interrupt strobe sets it again. The vector address is a constant output. A wake signal tells a sleeping core that an enabled source is pending, whether or not the global enable is set. Software reads and writes the flags, the enables and a small control register over a simple synchronous write and combinational read port.

Top module: `mcu_irq_ctrl`

## Requirements
- R1: A source event sets its flag one clock later, whatever that source's enable, the group enable and the global enable hold.
- R2: `irq_req` is high exactly when the global enable is 1 and some core source (flag bits 2..0) has both its flag and its enable set, or some peripheral source qualifies as in R3.
- R3: A peripheral source (flag bits 7..3) counts toward `irq_req` and `wake` only while the group enable (control bit 1) is 1.
- R4: `irq_ack` clears the global enable at the next clock edge. `irq_vector` always reads 0x0004.
- R5: `irq_ret` sets the global enable at the next clock edge. When `irq_ack` and `irq_ret` arrive together, the acknowledge wins. Both take priority over a software write of the control register.
- R6: After reset, every control, flag and enable bit is 0, and `irq_req` and `wake` are 0.
- R7: The external pin flag (bit 0) is set by a rising pin edge when edge select (control bit 2) is 1, and by a falling edge when it is 0. The flag is readable three clocks after the pin changes (two synchronizer flops, then one detect flop). The opposite edge does not set the flag.
- R8: Any change, in either direction, on `port_hi` (port bits 7..4) sets the port-change flag (bit 1). The change is detected against the last synchronized value, with the same three-clock latency as R7.
- R9: A flag changes to 0 only through a software write of the flag register. An event that arrives in the same cycle as a clearing write leaves the flag set.
- R10: `wake` is high whenever any enabled, qualified source is pending, even while the global enable is 0.
- R11: Register map: address 0 is control ([0] global enable, [1] group enable, [2] edge select, other bits read 0). Address 1 holds the flags and address 2 the enables, with the same layout: [0] external pin, [1] port change, [2] timer0, [3] A/D, [4] timer2, [5] serial, [6] capture/compare, [7] timer1. A write loads the written byte. Address 3 reads 0 and ignores writes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| ext_pin | input | 1 | External interrupt pin (asynchronous) |
| port_hi | input | 4 | Port bits 7..4 watched for change (asynchronous) |
| tmr0_ovf | input | 1 | Timer0 overflow pulse (0xFF to 0x00) |
| periph_evt | input | 5 | Peripheral pulses: [0] A/D, [1] timer2, [2] serial, [3] capture/compare, [4] timer1 |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Read data for `reg_addr` |
| irq_ack | input | 1 | CPU has taken the interrupt |
| irq_ret | input | 1 | Return-from-interrupt strobe |
| irq_req | output | 1 | Vector request to the CPU |
| irq_vector | output | 13 | Interrupt vector address |
| wake | output | 1 | Wake-from-sleep request |

## Verification
The embedded assertions check on every cycle that an event always leaves its flag set, that a set flag holds unless the flag register is written, that an acknowledge clears the global enable, that a return without an acknowledge sets it, and that a request never appears without a wake. Only the bench's scenarios can show the behaviour that depends on sequence or timing. This covers the three-clock synchronizer latency, the edge polarity choice, and change detection in both directions on the port nibble. It also covers the gating by the group enable, the race between a clearing write and a new event, the register map, and the ignored fourth address.

// File: rtl/mcu_irq_pkg.sv
package mcu_irq_pkg;
  localparam int N_CORE   = 3;
  localparam int N_PERIPH = 5;
  localparam int N_SRC    = N_CORE + N_PERIPH;
  localparam int REG_W    = 8;
  localparam int ADDR_W   = 2;

  localparam logic [ADDR_W-1:0] A_CTRL = 2'd0;
  localparam logic [ADDR_W-1:0] A_FLAG = 2'd1;
  localparam logic [ADDR_W-1:0] A_EN   = 2'd2;

  localparam int B_GIE  = 0;
  localparam int B_GRP  = 1;
  localparam int B_EDGE = 2;

  localparam int S_EXT  = 0;
  localparam int S_CHG  = 1;
  localparam int S_TMR0 = 2;
endpackage

// File: rtl/irq_sync_detect.sv
module irq_sync_detect #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] cur,
  output logic [W-1:0] prev
);
  logic [W-1:0] stg [STAGES];
  logic [W-1:0] last_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < STAGES; i++) stg[i] <= '0;
      last_q <= '0;
    end else begin
      stg[0] <= d;
      for (int i = 1; i < STAGES; i++) stg[i] <= stg[i-1];
      last_q <= stg[STAGES-1];
    end
  end

  assign cur  = stg[STAGES-1];
  assign prev = last_q;
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] evt,
  input  logic         wr,
  input  logic [N-1:0] wdata,
  output logic [N-1:0] flag
);
  logic [N-1:0] flag_q, flag_d;

  for (genvar i = 0; i < N; i++) begin : g_bit
    // hardware event wins over a clearing write
    always_comb flag_d[i] = (wr ? wdata[i] : flag_q[i]) | evt[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flag_q[i] <= 1'b0;
      else        flag_q[i] <= flag_d[i];
    end

    p_evt_sets_flag_r1: assert property (@(posedge clk) disable iff (!rst_n)
      evt[i] |=> flag_q[i]);
    p_flag_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_q[i] && !wr) |=> flag_q[i]);
  end

  assign flag = flag_q;
endmodule

// File: rtl/irq_gie_ctl.sv
module irq_gie_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic ack,
  input  logic ret,
  input  logic wr,
  input  logic wbit,
  output logic gie
);
  logic gie_q, gie_d;

  always_comb begin
    gie_d = gie_q;
    if (wr)  gie_d = wbit;
    if (ret) gie_d = 1'b1;
    if (ack) gie_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gie_q <= 1'b0;
    else        gie_q <= gie_d;
  end

  assign gie = gie_q;

  p_ack_clears_gie_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !gie_q);
  p_ret_sets_gie_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (ret && !ack) |=> gie_q);
endmodule

// File: rtl/mcu_irq_ctrl.sv
module mcu_irq_ctrl
  import mcu_irq_pkg::*;
#(
  parameter int          SYNC_STAGES = 2,
  parameter int          PC_W        = 13,
  parameter logic [12:0] VEC_ADDR    = 13'h0004
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ext_pin,
  input  logic [3:0]            port_hi,
  input  logic                  tmr0_ovf,
  input  logic [N_PERIPH-1:0]   periph_evt,
  input  logic                  reg_we,
  input  logic [ADDR_W-1:0]     reg_addr,
  input  logic [REG_W-1:0]      reg_wdata,
  output logic [REG_W-1:0]      reg_rdata,
  input  logic                  irq_ack,
  input  logic                  irq_ret,
  output logic                  irq_req,
  output logic [PC_W-1:0]       irq_vector,
  output logic                  wake
);
  logic       ext_cur, ext_prev;
  logic [3:0] prt_cur, prt_prev;
  logic       ext_evt, chg_evt;
  logic [N_SRC-1:0] evt, flag, act, grp_mask;
  logic [N_SRC-1:0] en_q, en_d;
  logic       grp_q, grp_d, edge_q, edge_d, gie;
  logic       wr_ctrl, wr_flag, wr_en;

  irq_sync_detect #(.W(1), .STAGES(SYNC_STAGES)) u_ext_sync (
    .clk(clk), .rst_n(rst_n), .d(ext_pin), .cur(ext_cur), .prev(ext_prev));
  irq_sync_detect #(.W(4), .STAGES(SYNC_STAGES)) u_prt_sync (
    .clk(clk), .rst_n(rst_n), .d(port_hi), .cur(prt_cur), .prev(prt_prev));

  always_comb begin
    ext_evt = edge_q ? (ext_cur & ~ext_prev) : (~ext_cur & ext_prev);
    chg_evt = |(prt_cur ^ prt_prev);
    evt     = {periph_evt, tmr0_ovf, chg_evt, ext_evt};
    wr_ctrl = reg_we && (reg_addr == A_CTRL);
    wr_flag = reg_we && (reg_addr == A_FLAG);
    wr_en   = reg_we && (reg_addr == A_EN);
  end

  irq_flag_bank #(.N(N_SRC)) u_flags (
    .clk(clk), .rst_n(rst_n), .evt(evt), .wr(wr_flag),
    .wdata(reg_wdata[N_SRC-1:0]), .flag(flag));

  irq_gie_ctl u_gie (
    .clk(clk), .rst_n(rst_n), .ack(irq_ack), .ret(irq_ret),
    .wr(wr_ctrl), .wbit(reg_wdata[B_GIE]), .gie(gie));

  // control and enable registers with explicit write enables
  always_comb begin
    en_d   = wr_en   ? reg_wdata[N_SRC-1:0] : en_q;
    grp_d  = wr_ctrl ? reg_wdata[B_GRP]     : grp_q;
    edge_d = wr_ctrl ? reg_wdata[B_EDGE]    : edge_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= '0;
      grp_q  <= 1'b0;
      edge_q <= 1'b0;
    end else begin
      en_q   <= en_d;
      grp_q  <= grp_d;
      edge_q <= edge_d;
    end
  end

  always_comb begin
    grp_mask = {{N_PERIPH{grp_q}}, {N_CORE{1'b1}}};
    act      = flag & en_q & grp_mask;
    wake     = |act;
    irq_req  = gie & wake;
  end

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      A_CTRL: begin
        reg_rdata[B_GIE]  = gie;
        reg_rdata[B_GRP]  = grp_q;
        reg_rdata[B_EDGE] = edge_q;
      end
      A_FLAG:  reg_rdata[N_SRC-1:0] = flag;
      A_EN:    reg_rdata[N_SRC-1:0] = en_q;
      default: reg_rdata = '0;
    endcase
  end

  assign irq_vector = PC_W'(VEC_ADDR);

  p_req_implies_wake_r10: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> wake);
  p_grp_blocks_periph_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!grp_q && !(|(flag[N_CORE-1:0] & en_q[N_CORE-1:0]))) |-> !wake);
endmodule

// File: tb/sim_mcu_irq_ctrl.sv
module sim_mcu_irq_ctrl;
  logic       clk, rst_n;
  logic       ext_pin, tmr0_ovf, reg_we, irq_ack, irq_ret;
  logic [3:0] port_hi;
  logic [4:0] periph_evt;
  logic [1:0] reg_addr;
  logic [7:0] reg_wdata, reg_rdata;
  logic       irq_req, wake;
  logic [12:0] irq_vector;

  mcu_irq_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .ext_pin(ext_pin), .port_hi(port_hi),
    .tmr0_ovf(tmr0_ovf), .periph_evt(periph_evt), .reg_we(reg_we),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .irq_ack(irq_ack), .irq_ret(irq_ret), .irq_req(irq_req),
    .irq_vector(irq_vector), .wake(wake));

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  typedef struct {
    int          kind;   // 0 rdata, 1 req, 2 wake, 3 vector
    logic [15:0] exp;
    string       tag;
  } item_t;
  item_t q[$];
  int n_chk = 0, n_fail = 0;
  bit done = 0;

  // monitor: pops one expected item per cycle, mid-cycle
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      logic [15:0] act;
      it = q.pop_front();
      case (it.kind)
        0: act = {8'h00, reg_rdata};
        1: act = {15'h0, irq_req};
        2: act = {15'h0, wake};
        default: act = {3'h0, irq_vector};
      endcase
      n_chk++;
      if (act !== it.exp) begin
        n_fail++;
        $display("FAIL %s: actual %h expected %h", it.tag, act, it.exp);
      end
    end
  end

  task automatic step();
    @(posedge clk); #1;
    reg_we = 0; irq_ack = 0; irq_ret = 0; tmr0_ovf = 0; periph_evt = '0;
  endtask
  task automatic idle(int n);
    for (int i = 0; i < n; i++) step();
  endtask
  task automatic wr(logic [1:0] a, logic [7:0] d);
    step(); reg_we = 1; reg_addr = a; reg_wdata = d;
  endtask
  task automatic exp_rd(logic [1:0] a, logic [7:0] e, string tag);
    item_t it;
    step(); reg_addr = a;
    it.kind = 0; it.exp = {8'h00, e}; it.tag = tag; q.push_back(it);
  endtask
  task automatic exp_sig(int k, logic [15:0] e, string tag);
    item_t it;
    step();
    it.kind = k; it.exp = e; it.tag = tag; q.push_back(it);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; ext_pin = 0; port_hi = 0; tmr0_ovf = 0; periph_evt = 0;
    reg_we = 0; reg_addr = 0; reg_wdata = 0; irq_ack = 0; irq_ret = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;

    // R6 reset state
    exp_rd(0, 8'h00, "R6 ctrl");
    exp_rd(1, 8'h00, "R6 flags");
    exp_rd(2, 8'h00, "R6 enables");
    exp_sig(1, 0, "R6 req");
    exp_sig(2, 0, "R6 wake");
    exp_sig(3, 16'h0004, "R4 vector");

    // R1 timer0 flag with everything masked
    step(); tmr0_ovf = 1;
    exp_rd(1, 8'h04, "R1 tmr0 flag while masked");
    exp_sig(2, 0, "R1 no wake when masked");
    // R10 wake with GIE clear, R2 no request
    wr(2, 8'h04);
    exp_sig(2, 1, "R10 wake without GIE");
    exp_sig(1, 0, "R2 no req without GIE");
    wr(0, 8'h01);
    exp_sig(1, 1, "R2 req with GIE");
    // R4 ack
    step(); irq_ack = 1;
    exp_rd(0, 8'h00, "R4 ack clears GIE");
    exp_sig(1, 0, "R4 req drops after ack");
    // R5 ret
    step(); irq_ret = 1;
    exp_rd(0, 8'h01, "R5 ret sets GIE");
    step(); irq_ack = 1; irq_ret = 1;
    exp_rd(0, 8'h00, "R5 ack wins over ret");
    step(); irq_ret = 1; reg_we = 1; reg_addr = 0; reg_wdata = 8'h00;
    exp_rd(0, 8'h01, "R5 ret wins over write");

    // R9 clear by write, and race with event
    wr(1, 8'h00);
    exp_rd(1, 8'h00, "R9 write clears flag");
    exp_sig(1, 0, "R9 req drops");
    wr(1, 8'h00); tmr0_ovf = 1;
    exp_rd(1, 8'h04, "R9 event beats clear");
    exp_sig(1, 1, "R2 req again");
    wr(1, 8'h00);
    wr(2, 8'h00);
    wr(0, 8'h00);

    // R3 peripheral group gating
    step(); periph_evt = 5'b00001;
    exp_rd(1, 8'h08, "R1 A/D flag");
    wr(2, 8'h08);
    wr(0, 8'h01);
    exp_sig(1, 0, "R3 req blocked by group");
    exp_sig(2, 0, "R3 wake blocked by group");
    wr(0, 8'h03);
    exp_sig(1, 1, "R3 req with group");
    step(); periph_evt = 5'b10000;
    exp_rd(1, 8'h88, "R1 timer1 flag bit7");
    wr(0, 8'h00);
    wr(1, 8'h00);
    wr(2, 8'h00);

    // R7 external edge polarity
    wr(0, 8'h04);
    step(); ext_pin = 1;
    idle(2);
    exp_rd(1, 8'h01, "R7 rising edge sets flag");
    wr(1, 8'h00);
    step(); ext_pin = 0;
    idle(2);
    exp_rd(1, 8'h00, "R7 falling ignored when rising selected");
    wr(0, 8'h00);
    step(); ext_pin = 1;
    idle(2);
    exp_rd(1, 8'h00, "R7 rising ignored when falling selected");
    step(); ext_pin = 0;
    idle(1);
    exp_rd(1, 8'h00, "R7 not yet after two clocks");
    exp_rd(1, 8'h01, "R7 falling edge sets flag");
    wr(1, 8'h00);

    // R8 port change
    step(); port_hi = 4'b0100;
    idle(2);
    exp_rd(1, 8'h02, "R8 port rise sets change flag");
    wr(1, 8'h00);
    step(); port_hi = 4'b0000;
    idle(2);
    exp_rd(1, 8'h02, "R8 port fall sets change flag");
    wr(1, 8'h00);
    idle(3);
    exp_rd(1, 8'h00, "R8 stable port leaves flag clear");

    // R11 register map
    wr(2, 8'hA5);
    exp_rd(2, 8'hA5, "R11 enable readback");
    wr(0, 8'hFF);
    exp_rd(0, 8'h07, "R11 ctrl unused bits read 0");
    wr(3, 8'hFF);
    exp_rd(3, 8'h00, "R11 address 3 reads 0");
    exp_rd(2, 8'hA5, "R11 address 3 write ignored");
    idle(2);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule